// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a small, synthesizable model of a pipelined synchronous SRAM. It registers its inputs and its outputs. On each rising clock edge it captures the address, a select, a global write enable and one write enable per 9-bit byte lane. A read returns its word from an output register one edge after the address was taken. A write takes its data from the input bus one cycle after the command was captured. That data waits in a one-entry write buffer and is written into the array later. The depth and the number of lanes are parameters.

The bidirectional data bus is split into `din`, `dout` and a drive enable `dout_en`. The output enable works either combinationally or through a register, and a parameter picks which. A power-down input blocks new commands at once. It still lets a write already in flight take its data and reach the array, so stored contents survive.

Top module: `lw_sram`

## Requirements
- R1: After reset `dout` is all zeros and no write is pending, so `dout_en` follows `oe_in`.
- R2: A read is accepted when `sel`=1, `wen`=0 and `pdn`=0 at a rising edge. The addressed word appears on `dout` after the next rising edge and stays there until the next accepted read.
- R3: A write is accepted when `sel`=1, `wen`=1 and `pdn`=0 at a rising edge. Its data is sampled from `din` at the following rising edge. The value on `din` at the command edge has no effect.
- R4: Lane i covers bits [9i+8:9i] of the word. A write changes only the lanes whose `lane_wen[i]` is 1. A mask of zero leaves the word unchanged.
- R5: A cycle with `sel`=0 is no operation: nothing is written and `dout` keeps its value.
- R6: An accepted write does not change `dout`.
- R7: A read always returns the latest written data. This holds when it is issued in the data cycle of a write to the same address. It also holds when two back-to-back partial writes hit that address, merged lane by lane.
- R8: With the default combinational output enable, `dout_en` follows `oe_in` within the same cycle, without waiting for a clock edge.
- R9: `dout_en` is 0 throughout the cycle after an accepted write, which is the cycle in which its data is sampled.
- R10: While `pdn`=1, no read or write is accepted and `dout` holds. A write accepted before `pdn` rose still samples its data and is committed to the array. Stored words survive power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Synchronous select; high marks an active cycle |
| wen | input | 1 | Global write enable; high chooses write over read |
| lane_wen | input | LANES | Per-lane write selects, bit i for lane i |
| addr | input | log2(DEPTH) | Word address |
| din | input | LANES*LANE_W | Write data, sampled one cycle after its command |
| oe_in | input | 1 | Output enable request |
| pdn | input | 1 | Asynchronous power-down; blocks new commands |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive enable for the data outputs (0 = high impedance) |

## Verification
The bench sweeps every address and every lane mask and computes the expected words arithmetically. A block that sampled write data at the command edge would store the inverted decoy value that the bench places on `din` there. A block with wrong lane decoding would change or keep the wrong 9-bit slices. Reads are issued in the very cycle in which write data arrives, and after two partial writes to one word. A block without a bypass around the write buffer would return stale lanes in those cases. Power-down is raised during a write's data cycle and held while new commands are offered. A block that dropped the pending write, or that accepted commands under power-down, would read back the wrong word afterwards or show a changed `dout`.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
   // Output enable timing variants.
   typedef enum logic [0:0] {
      OE_COMB = 1'b0,
      OE_REG  = 1'b1
   } oe_mode_e;

   localparam int unsigned LANE_BITS_DEF = 9;
endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
   parameter  int LANES  = 2,
   parameter  int LANE_W = 9,
   parameter  int DEPTH  = 16,
   localparam int AW     = $clog2(DEPTH),
   localparam int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic [LANES-1:0] we,
   input  logic [AW-1:0]    waddr,
   input  logic [W-1:0]     wdata,
   input  logic [AW-1:0]    raddr,
   output logic [W-1:0]     rdata
);
   // One storage column per lane so each lane has its own write strobe.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
   parameter  int LANES  = 2,
   parameter  int LANE_W = 9,
   parameter  int DEPTH  = 16,
   localparam int AW     = $clog2(DEPTH),
   localparam int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pdn,
   input  logic             cmd_take,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [LANES-1:0] cmd_lanes,
   input  logic [W-1:0]     din,
   input  logic [AW-1:0]    rd_addr,
   input  logic [W-1:0]     arr_rdata,
   output logic             data_phase,
   output logic [LANES-1:0] cmt_we,
   output logic [AW-1:0]    cmt_addr,
   output logic [W-1:0]     cmt_data,
   output logic [W-1:0]     rd_data
);
   // Stage 1: accepted command waiting for its data.
   logic             cmd_v;
   logic [AW-1:0]    cmd_a;
   logic [LANES-1:0] cmd_l;
   // Stage 2: buffered write holding address, lanes and data.
   logic             buf_v;
   logic [AW-1:0]    buf_a;
   logic [LANES-1:0] buf_l;
   logic [W-1:0]     buf_d;
   logic             commit;
   logic             hit;

   // The old entry drains when new data arrives or when power-down starts.
   assign commit     = buf_v & (cmd_v | pdn);
   assign data_phase = cmd_v;
   assign cmt_we     = buf_l & {LANES{commit}};
   assign cmt_addr   = buf_a;
   assign cmt_data   = buf_d;
   assign hit        = buf_v & (buf_a == rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_v <= 1'b0;
         cmd_a <= '0;
         cmd_l <= '0;
         buf_v <= 1'b0;
         buf_a <= '0;
         buf_l <= '0;
         buf_d <= '0;
      end else begin
         cmd_v <= cmd_take;
         if (cmd_take) begin
            cmd_a <= cmd_addr;
            cmd_l <= cmd_lanes;
         end
         if (cmd_v) begin
            buf_v <= 1'b1;
            buf_a <= cmd_a;
            buf_l <= cmd_l;
            buf_d <= din;
         end else if (commit) begin
            buf_v <= 1'b0;
         end
      end
   end

   // Read bypass: buffered lanes override the array lane by lane.
   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign rd_data[g*LANE_W +: LANE_W] = (hit && buf_l[g]) ? buf_d[g*LANE_W +: LANE_W]
                                                              : arr_rdata[g*LANE_W +: LANE_W];
   end

   AST_LATE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_v |=> (buf_v && buf_d == $past(din))); // R3
   AST_PDN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn && buf_v && !cmd_v) |=> !buf_v); // R10
   AST_PDN_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      pdn |=> !cmd_v); // R10
endmodule

// File: rtl/lw_sram_oe.sv
module lw_sram_oe
   import lw_sram_pkg::*;
#(
   parameter oe_mode_e OE_MODE = OE_COMB
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_in,
   input  logic block,
   output logic oe_out
);
   logic oe_q;
   logic oe_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= oe_in;
   end

   assign oe_eff = (OE_MODE == OE_REG) ? oe_q : oe_in;
   assign oe_out = oe_eff & ~block;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter  int       LANES   = 2,
   parameter  int       LANE_W  = LANE_BITS_DEF,
   parameter  int       DEPTH   = 16,
   parameter  oe_mode_e OE_MODE = OE_COMB,
   localparam int       AW      = $clog2(DEPTH),
   localparam int       W       = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wen,
   input  logic [LANES-1:0] lane_wen,
   input  logic [AW-1:0]    addr,
   input  logic [W-1:0]     din,
   input  logic             oe_in,
   input  logic             pdn,
   output logic [W-1:0]     dout,
   output logic             dout_en
);
   if (LANES < 1 || LANE_W < 1) begin : g_bad_width
      $error("lw_sram: LANES and LANE_W must be positive");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lw_sram: DEPTH must be a power of two of at least 2");
   end

   logic             rd_take, wr_take;
   logic             rd_v;
   logic [AW-1:0]    rd_a;
   logic [W-1:0]     dout_q;
   logic             data_phase;
   logic [LANES-1:0] cmt_we;
   logic [AW-1:0]    cmt_addr;
   logic [W-1:0]     cmt_data;
   logic [W-1:0]     arr_rdata;
   logic [W-1:0]     rd_data;

   // Power-down gates acceptance without waiting for a clock edge.
   assign rd_take = sel & ~wen & ~pdn;
   assign wr_take = sel &  wen & ~pdn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_v   <= 1'b0;
         rd_a   <= '0;
         dout_q <= '0;
      end else begin
         rd_v <= rd_take;
         if (rd_take) rd_a <= addr;
         if (rd_v) dout_q <= rd_data;
      end
   end
   assign dout = dout_q;

   lw_sram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) array_i (
      .clk   (clk),
      .we    (cmt_we),
      .waddr (cmt_addr),
      .wdata (cmt_data),
      .raddr (rd_a),
      .rdata (arr_rdata)
   );

   lw_sram_wbuf #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) wbuf_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pdn        (pdn),
      .cmd_take   (wr_take),
      .cmd_addr   (addr),
      .cmd_lanes  (lane_wen),
      .din        (din),
      .rd_addr    (rd_a),
      .arr_rdata  (arr_rdata),
      .data_phase (data_phase),
      .cmt_we     (cmt_we),
      .cmt_addr   (cmt_addr),
      .cmt_data   (cmt_data),
      .rd_data    (rd_data)
   );

   lw_sram_oe #(.OE_MODE(OE_MODE)) oe_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_in  (oe_in),
      .block  (data_phase),
      .oe_out (dout_en)
   );

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_v |=> $stable(dout)); // R5
   AST_WRITE_KEEPS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_take && !rd_v) |=> $stable(dout)); // R6
   AST_OE_OFF_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      data_phase |-> !dout_en); // R9
   AST_PDN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pdn |=> !rd_v); // R10
endmodule

// File: tb/lw_sram_tb_top.sv
`timescale 1ns/1ps
module lw_sram_tb_top;
   localparam int LANES = 2;
   localparam int LANE_W = 9;
   localparam int DEPTH = 16;
   localparam int AW = 4;
   localparam int W = LANES * LANE_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel = 1'b0;
   logic             wen = 1'b0;
   logic             oe_in = 1'b1;
   logic             pdn = 1'b0;
   logic [LANES-1:0] lane_wen = '0;
   logic [AW-1:0]    addr = '0;
   logic [W-1:0]     din = '0;
   logic [W-1:0]     dout;
   logic             dout_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [W-1:0] model [DEPTH];

   always #4 clk = ~clk;

   lw_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wen(wen), .lane_wen(lane_wen),
      .addr(addr), .din(din), .oe_in(oe_in), .pdn(pdn),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [LANES-1:0] m, logic [W-1:0] d);
      logic [W-1:0] r = old;
      for (int i = 0; i < LANES; i++)
         if (m[i]) r[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
      return r;
   endfunction

   function automatic logic [W-1:0] pat(int a, int m, int s);
      return W'(a * 4093 + m * 517 + s * 1237 + 7);
   endfunction

   // Drive at a falling edge, pass one rising edge, return at the next falling edge.
   task automatic cyc(bit s, bit w, logic [LANES-1:0] l, logic [AW-1:0] a, logic [W-1:0] d);
      sel = s; wen = w; lane_wen = l; addr = a; din = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_full(logic [AW-1:0] a, logic [LANES-1:0] l, logic [W-1:0] d);
      cyc(1'b1, 1'b1, l, a, ~d);
      chk("R9 dout_en in data cycle", W'(dout_en), W'(0));
      cyc(1'b0, 1'b0, '0, '0, d);
      model[a] = merge(model[a], l, d);
   endtask

   task automatic rd(logic [AW-1:0] a);
      cyc(1'b1, 1'b0, '0, a, '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 dout after reset", dout, '0);
      chk("R1 dout_en after reset", W'(dout_en), W'(1));

      // Full-word fill and readback of every address.
      for (int a = 0; a < DEPTH; a++) begin
         model[a] = '0;
         wr_full(AW'(a), 2'b11, pat(a, 3, 0));
      end
      for (int a = 0; a < DEPTH; a++) begin
         rd(AW'(a));
         chk("R2 read latency", dout, model[a]);
      end

      // Every lane mask at every address; even masks read in the data cycle.
      for (int a = 0; a < DEPTH; a++) begin
         for (int m = 0; m < 4; m++) begin
            logic [W-1:0] d = pat(a, m, 1);
            if ((m % 2) == 0) begin
               cyc(1'b1, 1'b1, LANES'(m), AW'(a), ~d);
               chk("R9 dout_en in data cycle", W'(dout_en), W'(0));
               cyc(1'b1, 1'b0, '0, AW'(a), d);
               model[a] = merge(model[a], LANES'(m), d);
               cyc(1'b0, 1'b0, '0, '0, '0);
               chk("R7 read in data cycle", dout, model[a]);
            end else begin
               wr_full(AW'(a), LANES'(m), d);
               rd(AW'(a));
               chk("R4 lane mask", dout, model[a]);
            end
         end
      end

      // Two partial writes back to back, then an immediate read.
      begin
         logic [W-1:0] d1 = pat(7, 1, 2);
         logic [W-1:0] d2 = pat(7, 2, 3);
         cyc(1'b1, 1'b1, 2'b01, 4'd7, ~d1);
         cyc(1'b1, 1'b1, 2'b10, 4'd7, d1);
         model[7] = merge(model[7], 2'b01, d1);
         cyc(1'b1, 1'b0, '0, 4'd7, d2);
         model[7] = merge(model[7], 2'b10, d2);
         cyc(1'b0, 1'b0, '0, '0, '0);
         chk("R7 back-to-back partial writes", dout, model[7]);
      end

      // sel low with write enable high does nothing.
      begin
         logic [W-1:0] prev;
         rd(4'd1);
         prev = dout;
         cyc(1'b0, 1'b1, 2'b11, 4'd2, ~pat(2, 0, 9));
         cyc(1'b0, 1'b1, 2'b11, 4'd2, pat(2, 0, 9));
         chk("R5 dout holds when idle", dout, prev);
         rd(4'd2);
         chk("R5 no write without sel", dout, model[2]);
      end

      // A write leaves dout alone.
      begin
         logic [W-1:0] prev;
         rd(4'd3);
         prev = dout;
         wr_full(4'd4, 2'b11, pat(4, 3, 5));
         chk("R6 write keeps dout", dout, prev);
         rd(4'd4);
         chk("R3 late data stored", dout, model[4]);
      end

      // Combinational output enable.
      oe_in = 1'b0;
      #1;
      chk("R8 oe low", W'(dout_en), W'(0));
      oe_in = 1'b1;
      #1;
      chk("R8 oe high", W'(dout_en), W'(1));
      @(negedge clk);

      // Power-down during a write's data cycle.
      begin
         logic [W-1:0] d = pat(5, 3, 6);
         logic [W-1:0] prev;
         rd(4'd0);
         prev = dout;
         cyc(1'b1, 1'b1, 2'b11, 4'd5, ~d);
         pdn = 1'b1;
         cyc(1'b0, 1'b0, '0, '0, d);
         model[5] = d;
         cyc(1'b1, 1'b1, 2'b11, 4'd6, ~pat(6, 3, 6));
         cyc(1'b0, 1'b0, '0, '0, pat(6, 3, 6));
         cyc(1'b1, 1'b0, '0, 4'd5, '0);
         cyc(1'b0, 1'b0, '0, '0, '0);
         chk("R10 dout holds in power-down", dout, prev);
         pdn = 1'b0;
         cyc(1'b0, 1'b0, '0, '0, '0);
         rd(4'd5);
         chk("R10 pending write survives", dout, model[5]);
         rd(4'd6);
         chk("R10 write ignored in power-down", dout, model[6]);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule